// File: doc/BRIEF.md
# NAND Sector BCH Parity Encoder

This block computes the parity of an 8-error-correcting binary BCH code over 512-byte NAND sectors while the data streams past. The data arrives on a bus that is either 8 or 16 bits wide. The code is defined over GF(2^13) with the field polynomial 0x201B. Its generator has degree 104, so each sector yields a 104-bit remainder. The generator is a constant computed at elaboration: the product of the minimal polynomials of alpha^1, alpha^3, ..., alpha^15. Bits enter the shift register most significant bit first within each byte. On a 16-bit bus the low byte of each word goes in before the high byte.

A run covers 1 to 8 back-to-back sectors. Each sector has its own remainder bank, and the first byte of a sector always starts that bank from a zero remainder. Software programs a configuration byte and streams the data. It then reads each bank either as four 32-bit words or as 13 masked ECC bytes. The mask makes an erased (all-0xFF) sector give all-0xFF ECC. A clear pulse zeroes every bank.

A three-state controller sequences the run:
- ST_IDLE: data is ignored.
- ST_RUN: data accumulates.
- ST_DONE: the programmed count is reached and data is ignored.

The controller has these transitions:
- IDLE→RUN and DONE→RUN, and RUN→RUN as a restart: a configuration write with enable set.
- Any state→IDLE: a configuration write with enable clear, or a clear pulse. The clear pulse has priority.
- RUN→DONE: the last byte of the last programmed sector is accepted.

Top module: `nbe_engine`

## Requirements
- R1: After reset the block is idle (busy=0, done=0) and every bank holds a zero remainder, so its ecc_out equals the mask EF 51 2E 09 ED 93 9A C2 97 79 E5 24 B5. In ecc_out, byte 0 sits in bits 103:96, and each following byte sits 8 bits lower.
- R2: A sector of 512 zero bytes leaves a zero remainder, so ecc_out equals the mask.
- R3: A sector of 512 bytes of 0xFF produces ecc_out of thirteen 0xFF bytes.
- R4: The remainder is linear. For sectors A, B and A^B (bytewise XOR), ecc(A^B) = ecc(A) ^ ecc(B) ^ mask.
- R5: With the bus-width bit (configuration bit 7) set, each beat carries two bytes and the low byte is processed first. A sector of 256 words gives the same result as the same 512 bytes sent on the 8-bit bus.
- R6: Configuration bits 6:4 hold the sector count minus one. Each sector of a run lands in its own bank, in order. done rises only after the last byte of the last sector, and data offered while done is set is ignored.
- R7: Every sector starts from a zero remainder, so identical sector data gives identical ECC in any bank.
- R8: Read word w (rd_word) of the selected bank returns these remainder bits:
  - word 0: bits 31:0
  - word 1: bits 63:32
  - word 2: bits 95:64
  - word 3: bits 103:96 in its low byte, with bits 31:8 zero.
- R9: A clear pulse zeroes every bank and returns the block to idle with done=0.
- R10: A configuration write with bit 0 clear stops accumulation at once. After it, data beats leave every bank unchanged.
- R11: A configuration write with bit 0 set starts a fresh run at bank 0, byte 0, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [0] enable, [6:4] sectors minus one, [7] 16-bit bus; bits 3:1 are ignored |
| clr | input | 1 | Clear pulse: zero all banks, go idle |
| data_valid | input | 1 | Data beat valid |
| data_in | input | 16 | Beat data; only [7:0] is used on the 8-bit bus |
| rd_sel | input | 3 | Bank selected for readback |
| rd_word | input | 2 | Result word selected within the bank |
| rd_data | output | 32 | Selected result word |
| ecc_out | output | 104 | Masked ECC bytes of the selected bank, byte 0 in bits 103:96 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Programmed sector count reached |

## Verification
The assertions check the control behaviour on every cycle:
- a clear or a configuration write puts the controller in its named next state, and a clear empties the banks;
- while not accumulating, the banks do not change;
- done rises only on an accepted beat;
- the padding of result word 3 stays zero.

Only the bench's scenarios can show that the arithmetic is right. That covers the erased-sector and zero-sector values, linearity across sectors, the equivalence of the 16-bit and 8-bit byte orders, and the per-sector restart of the remainder.

// File: rtl/nbe_pkg.sv
package nbe_pkg;

    localparam int GF_M   = 13;
    localparam int BCH_T  = 8;
    localparam int PAR_W  = GF_M * BCH_T;
    localparam logic [GF_M:0] GF_PRIM = 14'h201B;

    // Byte 0 of the mask sits in the most significant byte.
    localparam logic [PAR_W-1:0] ECC_MASK = 104'hEF512E09ED939AC29779E524B5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } nbe_state_e;

    // Multiply two field elements modulo the field polynomial.
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] r;
        r = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            r = {r[GF_M-2:0], 1'b0} ^ (r[GF_M-1] ? GF_PRIM[GF_M-1:0] : '0);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // Generator = product of minimal polynomials of alpha^1, alpha^3, ... alpha^(2T-1).
    function automatic logic [PAR_W:0] gen_poly();
        logic [PAR_W:0]           g;
        logic [PAR_W:0]           prod;
        logic [GF_M:0][GF_M-1:0]  c;
        logic [GF_M-1:0]          root;
        g    = '0;
        g[0] = 1'b1;
        for (int i = 1; i < 2 * BCH_T; i += 2) begin
            root = GF_M'(1);
            for (int n = 0; n < i; n++) root = gf_mul(root, GF_M'(2));
            c    = '0;
            c[0] = GF_M'(1);
            // Multiply (x + beta) over all conjugates beta of alpha^i.
            for (int j = 0; j < GF_M; j++) begin
                for (int k = GF_M; k > 0; k--) c[k] = c[k-1] ^ gf_mul(c[k], root);
                c[0] = gf_mul(c[0], root);
                root = gf_mul(root, root);
            end
            prod = '0;
            for (int k = 0; k <= GF_M; k++) begin
                if (c[k][0]) prod = prod ^ (g << k);
            end
            g = prod;
        end
        return g;
    endfunction

    localparam logic [PAR_W:0]   GEN_FULL = gen_poly();
    localparam logic [PAR_W-1:0] GEN_LOW  = GEN_FULL[PAR_W-1:0];

endpackage

// File: rtl/nbe_lfsr.sv
module nbe_lfsr #(
    parameter int PAR_W  = nbe_pkg::PAR_W,
    parameter int BYTE_W = 8,
    parameter int BUS_W  = 16
) (
    input  logic [PAR_W-1:0] rem_in,
    input  logic [BUS_W-1:0] data,
    input  logic             wide,
    output logic [PAR_W-1:0] rem_out
);

    localparam logic [PAR_W-1:0] GEN = nbe_pkg::GEN_LOW[PAR_W-1:0];

    function automatic logic [PAR_W-1:0] shift1(input logic [PAR_W-1:0] r,
                                                input logic             b);
        logic fb;
        fb = r[PAR_W-1] ^ b;
        return {r[PAR_W-2:0], 1'b0} ^ (fb ? GEN : '0);
    endfunction

    logic [PAR_W-1:0] after_lo;

    // Low byte always, most significant bit first.
    always_comb begin
        after_lo = rem_in;
        for (int b = BYTE_W - 1; b >= 0; b--) after_lo = shift1(after_lo, data[b]);
    end

    generate
        if (BUS_W > BYTE_W) begin : g_wide
            logic [PAR_W-1:0] after_hi;
            always_comb begin
                after_hi = after_lo;
                for (int b = BUS_W - 1; b >= BYTE_W; b--) after_hi = shift1(after_hi, data[b]);
                rem_out = wide ? after_hi : after_lo;
            end
        end else begin : g_narrow
            logic wide_unused;
            assign wide_unused = wide;
            assign rem_out     = after_lo;
        end
    endgenerate

endmodule

// File: rtl/nbe_ctrl.sv
module nbe_ctrl #(
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_SECTORS  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic                           cfg_en,
    input  logic [$clog2(MAX_SECTORS)-1:0] cfg_last,
    input  logic                           cfg_wide,
    input  logic                           clr,
    input  logic                           data_valid,
    output logic                           accept,
    output logic                           first,
    output logic [$clog2(MAX_SECTORS)-1:0] bank_idx,
    output logic                           wide,
    output logic                           busy,
    output logic                           done
);

    import nbe_pkg::*;

    localparam int CNT_W = $clog2(SECTOR_BYTES);
    localparam int IDX_W = $clog2(MAX_SECTORS);
    localparam logic [CNT_W:0] SEC_LEN = (CNT_W + 1)'(SECTOR_BYTES);

    nbe_state_e       state_q, state_d;
    logic [CNT_W-1:0] byte_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;
    logic             wide_q;
    logic [CNT_W:0]   step;
    logic [CNT_W:0]   byte_sum;
    logic             sector_end;
    logic             last_sector;

    assign step        = wide_q ? (CNT_W + 1)'(2) : (CNT_W + 1)'(1);
    assign byte_sum    = {1'b0, byte_q} + step;
    assign accept      = (state_q == ST_RUN) && data_valid;
    assign sector_end  = accept && (byte_sum == SEC_LEN);
    assign last_sector = (idx_q == last_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_IDLE;
        end else if (cfg_we) begin
            state_d = cfg_en ? ST_RUN : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  if (sector_end && last_sector) state_d = ST_DONE;
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Position counters and latched configuration.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            wide_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                last_q <= cfg_last;
                wide_q <= cfg_wide;
            end
            if (clr || cfg_we) begin
                byte_q <= '0;
                idx_q  <= '0;
            end else if (accept) begin
                if (sector_end) begin
                    byte_q <= '0;
                    if (!last_sector) idx_q <= idx_q + IDX_W'(1);
                end else begin
                    byte_q <= byte_sum[CNT_W-1:0];
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
        first    = (byte_q == '0);
        bank_idx = idx_q;
        wide     = wide_q;
    end

endmodule

// File: rtl/nbe_bank.sv
module nbe_bank #(
    parameter int PAR_W       = nbe_pkg::PAR_W,
    parameter int MAX_SECTORS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr_en,
    input  logic [$clog2(MAX_SECTORS)-1:0] wr_idx,
    input  logic [PAR_W-1:0]               wr_data,
    output logic [PAR_W-1:0]               cur_rem,
    input  logic [$clog2(MAX_SECTORS)-1:0] rd_sel,
    output logic [PAR_W-1:0]               rd_rem
);

    logic [MAX_SECTORS-1:0][PAR_W-1:0] bank_w;

    generate
        for (genvar g = 0; g < MAX_SECTORS; g++) begin : g_bank
            logic [PAR_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                   q <= '0;
                else if (clr)                                 q <= '0;
                else if (wr_en && (int'(wr_idx) == g))        q <= wr_data;
            end
            assign bank_w[g] = q;
        end
    endgenerate

    assign cur_rem = bank_w[wr_idx];
    assign rd_rem  = bank_w[rd_sel];

endmodule

// File: rtl/nbe_ecc_pack.sv
module nbe_ecc_pack #(
    parameter int PAR_W  = nbe_pkg::PAR_W,
    parameter int WORD_W = 32
) (
    input  logic [PAR_W-1:0]                                rem,
    input  logic [$clog2((PAR_W+WORD_W-1)/WORD_W)-1:0]      rd_word,
    output logic [WORD_W-1:0]                               rd_data,
    output logic [PAR_W-1:0]                                ecc_out
);

    localparam int NWORDS = (PAR_W + WORD_W - 1) / WORD_W;
    localparam int PAD_W  = NWORDS * WORD_W;

    logic [PAD_W-1:0] padded;

    assign padded  = {{(PAD_W - PAR_W){1'b0}}, rem};
    assign rd_data = padded[rd_word * WORD_W +: WORD_W];
    assign ecc_out = rem ^ nbe_pkg::ECC_MASK[PAR_W-1:0];

endmodule

// File: rtl/nbe_engine.sv
module nbe_engine #(
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_SECTORS  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [7:0]                     cfg_wdata,
    input  logic                           clr,
    input  logic                           data_valid,
    input  logic [15:0]                    data_in,
    input  logic [$clog2(MAX_SECTORS)-1:0] rd_sel,
    input  logic [1:0]                     rd_word,
    output logic [31:0]                    rd_data,
    output logic [nbe_pkg::PAR_W-1:0]      ecc_out,
    output logic                           busy,
    output logic                           done
);

    localparam int PAR_W    = nbe_pkg::PAR_W;
    localparam int IDX_W    = $clog2(MAX_SECTORS);
    localparam int EN_BIT   = 0;
    localparam int CNT_LSB  = 4;
    localparam int WIDE_BIT = 7;

    logic             accept;
    logic             first;
    logic [IDX_W-1:0] bank_idx;
    logic             wide;
    logic [PAR_W-1:0] cur_rem;
    logic [PAR_W-1:0] base_rem;
    logic [PAR_W-1:0] next_rem;
    logic [PAR_W-1:0] rd_rem;
    logic             cfg_unused;

    assign cfg_unused = ^cfg_wdata[CNT_LSB-1:EN_BIT+1];

    nbe_ctrl #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .MAX_SECTORS  (MAX_SECTORS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_en     (cfg_wdata[EN_BIT]),
        .cfg_last   (cfg_wdata[CNT_LSB +: IDX_W]),
        .cfg_wide   (cfg_wdata[WIDE_BIT]),
        .clr        (clr),
        .data_valid (data_valid),
        .accept     (accept),
        .first      (first),
        .bank_idx   (bank_idx),
        .wide       (wide),
        .busy       (busy),
        .done       (done)
    );

    // A sector's first beat starts from a zero remainder.
    assign base_rem = first ? '0 : cur_rem;

    nbe_lfsr #(
        .PAR_W  (PAR_W),
        .BYTE_W (8),
        .BUS_W  (16)
    ) u_lfsr (
        .rem_in  (base_rem),
        .data    (data_in),
        .wide    (wide),
        .rem_out (next_rem)
    );

    nbe_bank #(
        .PAR_W       (PAR_W),
        .MAX_SECTORS (MAX_SECTORS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (accept),
        .wr_idx  (bank_idx),
        .wr_data (next_rem),
        .cur_rem (cur_rem),
        .rd_sel  (rd_sel),
        .rd_rem  (rd_rem)
    );

    nbe_ecc_pack #(
        .PAR_W  (PAR_W),
        .WORD_W (32)
    ) u_pack (
        .rem     (rd_rem),
        .rd_word (rd_word),
        .rd_data (rd_data),
        .ecc_out (ecc_out)
    );

endmodule

// File: rtl/nbe_engine_chk.sv
module nbe_engine_chk #(
    parameter int MAX_SECTORS = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_we,
    input logic [7:0]                     cfg_wdata,
    input logic                           clr,
    input logic                           data_valid,
    input logic [$clog2(MAX_SECTORS)-1:0] rd_sel,
    input logic [1:0]                     rd_word,
    input logic [31:0]                    rd_data,
    input logic [nbe_pkg::PAR_W-1:0]      ecc_out,
    input logic                           busy,
    input logic                           done
);

    // R9: clear leaves the controller idle.
    p_clear_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !done));

    // R9: clear empties the banks, so the selected bank shows the bare mask.
    p_clear_zeroes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ecc_out == nbe_pkg::ECC_MASK));

    // R11: enabling write starts a run.
    p_enable_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[0] && !clr) |=> (busy && !done));

    // R10: disabling write stops at once.
    p_disable_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[0] && !clr) |=> (!busy && !done));

    // R10 / R6: without a run, bank contents do not move.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> (!$stable(rd_sel) || $stable(ecc_out)));

    // R6: completion only follows an accepted beat.
    p_done_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(data_valid));

    // R8: upper bits of the last result word are padding.
    p_word3_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word == 2'd3) |-> (rd_data[31:8] == 24'h0));

endmodule

bind nbe_engine nbe_engine_chk #(.MAX_SECTORS(MAX_SECTORS)) i_nbe_engine_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .clr        (clr),
    .data_valid (data_valid),
    .rd_sel     (rd_sel),
    .rd_word    (rd_word),
    .rd_data    (rd_data),
    .ecc_out    (ecc_out),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_nbe_engine.sv
`timescale 1ns/1ps
module test_nbe_engine;

    localparam int  CLK_PERIOD = 20;
    localparam logic [103:0] MASK   = 104'hEF512E09ED939AC29779E524B5;
    localparam logic [103:0] ALL_FF = {13{8'hFF}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_wdata = '0;
    logic         clr = 1'b0;
    logic         data_valid = 1'b0;
    logic [15:0]  data_in = '0;
    logic [2:0]   rd_sel = '0;
    logic [1:0]   rd_word = '0;
    logic [31:0]  rd_data;
    logic [103:0] ecc_out;
    logic         busy;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nbe_engine i_nbe_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .clr(clr), .data_valid(data_valid), .data_in(data_in),
        .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data),
        .ecc_out(ecc_out), .busy(busy), .done(done)
    );

    typedef struct {
        int           sel;
        logic [103:0] exp;
        bit           cap;
        string        tag;
    } item_t;

    item_t        sb_q[$];
    bit           mon_req = 1'b0;
    logic [103:0] cap_ecc [8];

    task automatic chk(input bit ok, input string tag,
                       input logic [103:0] act, input logic [103:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input int kind, input int i);
        logic [7:0] a, b;
        a = 8'((i * 37 + 11) ^ (i >> 3));
        b = 8'((i * 91 + 5) ^ (i >> 1) ^ 8'h5A);
        case (kind)
            0: return 8'h00;
            1: return 8'hFF;
            2: return a;
            3: return b;
            default: return a ^ b;
        endcase
    endfunction

    // Monitor: pops expected items and compares bank contents.
    initial begin
        item_t        it;
        logic [31:0]  w [4];
        logic [103:0] e;
        logic [103:0] rem;
        bit           pack_ok;
        forever begin
            wait (mon_req);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    rd_sel  = 3'(it.sel);
                    rd_word = 2'(k);
                    #2;
                    w[k] = rd_data;
                    e    = ecc_out;
                end
                if (it.cap) begin
                    cap_ecc[it.sel] = e;
                end else begin
                    chk(e == it.exp, it.tag, e, it.exp);
                    rem = it.exp ^ MASK;
                    pack_ok = (w[0] == rem[31:0]) && (w[1] == rem[63:32]) &&
                              (w[2] == rem[95:64]) && (w[3] == {24'h0, rem[103:96]});
                    chk(pack_ok, {"R8 packing ", it.tag},
                        {w[3][7:0], w[2], w[1], w[0]}, rem);
                end
            end
            mon_req = 1'b0;
        end
    end

    task automatic push(input int sel, input logic [103:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.cap = 1'b0; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic push_cap(input int sel);
        item_t it;
        it.sel = sel; it.exp = '0; it.cap = 1'b1; it.tag = "cap";
        sb_q.push_back(it);
    endtask

    task automatic flush();
        mon_req = 1'b1;
        wait (!mon_req);
    endtask

    task automatic cfg(input bit en, input int last, input bit wide);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {wide, 3'(last), 3'b000, en};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Send bytes [from, to) of pattern kind; indices taken modulo the sector.
    task automatic send_bytes(input int kind, input int from, input int to, input bit wide);
        if (!wide) begin
            for (int i = from; i < to; i++) begin
                @(negedge clk);
                data_valid = 1'b1;
                data_in    = {8'h00, byte_of(kind, i % 512)};
            end
        end else begin
            for (int i = from; i < to; i += 2) begin
                @(negedge clk);
                data_valid = 1'b1;
                data_in    = {byte_of(kind, (i + 1) % 512), byte_of(kind, i % 512)};
            end
        end
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    initial begin
        logic [103:0] e_a, e_b, e_part;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(!busy && !done, "R1 idle after reset", {102'h0, busy, done}, '0);
        for (int s = 0; s < 8; s++) push(s, MASK, "R1 bank empty");
        flush();

        // R2: zero sector
        cfg(1'b1, 0, 1'b0);
        send_bytes(0, 0, 512, 1'b0);
        chk(done && !busy, "R2 done after one sector", {102'h0, busy, done}, 104'h1);
        push(0, MASK, "R2 zero sector");
        flush();

        // R3: erased sector
        pulse_clr();
        cfg(1'b1, 0, 1'b0);
        send_bytes(1, 0, 512, 1'b0);
        push(0, ALL_FF, "R3 erased sector");
        flush();

        // R4 / R7: four sectors A, B, A^B, A
        cfg(1'b1, 3, 1'b0);
        send_bytes(2, 0, 512, 1'b0);
        send_bytes(3, 0, 512, 1'b0);
        send_bytes(4, 0, 512, 1'b0);
        send_bytes(2, 0, 512, 1'b0);
        chk(done, "R6 done after four sectors", {103'h0, done}, 104'h1);
        push_cap(0);
        push_cap(1);
        flush();
        e_a = cap_ecc[0];
        e_b = cap_ecc[1];
        chk(e_a != e_b, "R4 distinct patterns", e_a, e_b);
        push(2, e_a ^ e_b ^ MASK, "R4 linearity");
        push(3, e_a, "R7 fresh start per sector");
        flush();

        // R5: 16-bit bus, low byte first
        cfg(1'b1, 0, 1'b1);
        send_bytes(2, 0, 512, 1'b1);
        chk(done, "R5 done after 256 words", {103'h0, done}, 104'h1);
        push(0, e_a, "R5 wide bus order");
        flush();

        // R6: full eight-sector run and done timing
        cfg(1'b1, 7, 1'b0);
        send_bytes(1, 0, 8 * 512 - 1, 1'b0);
        chk(!done && busy, "R6 not done before last byte", {102'h0, busy, done}, 104'h2);
        send_bytes(1, 0, 1, 1'b0);
        chk(done && !busy, "R6 done on last byte", {102'h0, busy, done}, 104'h1);
        send_bytes(0, 0, 64, 1'b0);
        for (int s = 0; s < 8; s++) push(s, ALL_FF, "R6 bank per sector, extra data ignored");
        flush();

        // R9: clear
        pulse_clr();
        chk(!busy && !done, "R9 idle after clear", {102'h0, busy, done}, '0);
        for (int s = 0; s < 8; s++) push(s, MASK, "R9 bank cleared");
        flush();

        // R10: stop mid-run, then beats are ignored
        cfg(1'b1, 0, 1'b0);
        send_bytes(2, 0, 100, 1'b0);
        cfg(1'b0, 0, 1'b0);
        chk(!busy && !done, "R10 stopped", {102'h0, busy, done}, '0);
        push_cap(0);
        flush();
        e_part = cap_ecc[0];
        send_bytes(3, 0, 50, 1'b0);
        push(0, e_part, "R10 data ignored when disabled");
        flush();

        // R11: restart from byte 0 of bank 0
        cfg(1'b1, 0, 1'b0);
        send_bytes(2, 0, 200, 1'b0);
        cfg(1'b1, 0, 1'b0);
        send_bytes(2, 0, 512, 1'b0);
        chk(done, "R11 restart completes", {103'h0, done}, 104'h1);
        push(0, e_a, "R11 restart fresh");
        flush();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule